// File: doc/BRIEF.md
# PWM Compare Channel with Auto-Reload Timer

This block pairs an up-counting timer with a single compare channel. On each count-enable tick the timer advances by one. When it steps past the all-ones value it restarts at a programmable reload value. The timer period is therefore `2^WIDTH - reload` ticks. A compare register, written by software through a simple write strobe, is checked against each count the timer steps onto. A hit raises a one-clock interrupt pulse. In pin mode the hit also drives the compare pin high, and the overflow back to the reload value drives it low, which produces a PWM waveform.

Only one hit is accepted per timer period, so rewriting the compare register after a hit has no effect until the next period. A compare value equal to the reload value is a genuine hit that still interrupts. In pin mode its set wins over the overflow clear, which gives a 100% duty cycle without any special handling. A compare value below the reload value is never reached, which gives 0% duty. Because hits are detected only when the timer steps onto a count, a value written at or behind the current count is first seen in the following period.

Top module: `pwm_cmp_channel`

## Requirements
- R1: While reset is asserted the timer is loaded with `reload_val`, `cmp_pin` is low and `cmp_irq` is low.
- R2: Each clock with `tick` high advances the timer by one. A tick taken at the all-ones count loads `reload_val` instead, so one period lasts `2^WIDTH - reload_val` ticks.
- R3: A hit is detected on the clock edge at which a tick moves the timer onto the compare value. `cmp_irq` is high in the clock cycle after that edge.
- R4: After a hit, no further hit is accepted until the timer reloads, even if the compare register is rewritten to a count still ahead of the timer.
- R5: A compare value equal to `reload_val` hits on the tick that reloads the timer and raises `cmp_irq` in both modes. In pin mode `cmp_pin` stays high across that overflow, giving 100% duty.
- R6: A compare value below `reload_val` never hits. No interrupt is raised, and in pin mode `cmp_pin` stays low (0% duty).
- R7: A compare value written at or behind the current count, while no hit has yet occurred this period, produces no interrupt in the current period. It hits in the next period.
- R8: With `mode_sel` = 0 (interrupt-only) `cmp_pin` keeps its level on every clock, hits and overflows included.
- R9: With `mode_sel` = 1 (pin mode) a hit sets `cmp_pin` and an overflow tick clears it. When both occur on the same tick, the set wins. `cmp_pin` changes in the same cycle as `cmp_irq`.
- R10: A compare write is captured at the clock edge where `cmp_wr` is high. A tick at that same edge is still checked against the old compare value.
- R11: `cmp_irq` is a single-cycle pulse per hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one timer step per high cycle |
| reload_val | input | WIDTH | Count loaded on reset and on overflow |
| mode_sel | input | 1 | 0 = interrupt-only, 1 = pin (PWM) mode |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | WIDTH | Compare value to write |
| cmp_pin | output | 1 | Compare output pin |
| cmp_irq | output | 1 | One-cycle compare interrupt pulse |

## Verification
The bound checker watches, on every cycle, that interrupts only follow a tick, that the pin is frozen in interrupt-only mode, that the pin rises only together with an interrupt, and that it falls only after a tick in pin mode. It also checks that reset forces both outputs low. The one-hit-per-period block, the 100% and 0% duty corners, and the deferral of a compare value written behind the timer all depend on the sequence of writes and period boundaries. Only the bench's scenarios show these, by counting interrupts and pin-high steps over whole periods.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
    typedef enum logic {
        MODE_IRQ_ONLY = 1'b0,
        MODE_PIN_PWM  = 1'b1
    } cmp_mode_e;
endpackage

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [WIDTH-1:0] reload_val,
    output logic [WIDTH-1:0] count_nx,
    output logic             wrap
);
    localparam logic [WIDTH-1:0] TOP = '1;

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        wrap     = tick && (st_q.count == TOP);
        count_nx = (st_q.count == TOP) ? reload_val : st_q.count + 1'b1;
        if (tick) begin
            st_d.count = count_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count <= reload_val;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwm_cmp_match.sv
module pwm_cmp_match #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wrap,
    input  logic [WIDTH-1:0] count_nx,
    input  logic             cmp_wr,
    input  logic [WIDTH-1:0] cmp_wdata,
    output logic             hit
);
    typedef struct packed {
        logic [WIDTH-1:0] cmp;
        logic             blocked;
    } match_state_t;

    match_state_t st_d, st_q;
    logic         armed;

    always_comb begin
        st_d  = st_q;
        // a reload reopens the window for the count it lands on
        armed = wrap || !st_q.blocked;
        hit   = tick && armed && (count_nx == st_q.cmp);
        if (hit) begin
            st_d.blocked = 1'b1;
        end else if (wrap) begin
            st_d.blocked = 1'b0;
        end
        if (cmp_wr) begin
            st_d.cmp = cmp_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwm_cmp_channel.sv
module pwm_cmp_channel
    import pwm_cmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [WIDTH-1:0] reload_val,
    input  logic             mode_sel,
    input  logic             cmp_wr,
    input  logic [WIDTH-1:0] cmp_wdata,
    output logic             cmp_pin,
    output logic             cmp_irq
);
    typedef struct packed {
        logic pin;
        logic irq;
    } out_state_t;

    out_state_t st_d, st_q;
    logic [WIDTH-1:0] count_nx;
    logic             wrap;
    logic             hit;
    cmp_mode_e        mode;

    pwm_cmp_timer #(.WIDTH(WIDTH)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .reload_val (reload_val),
        .count_nx   (count_nx),
        .wrap       (wrap)
    );

    pwm_cmp_match #(.WIDTH(WIDTH)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wrap      (wrap),
        .count_nx  (count_nx),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .hit       (hit)
    );

    always_comb begin
        mode     = cmp_mode_e'(mode_sel);
        st_d     = st_q;
        st_d.irq = hit;
        if (mode == MODE_PIN_PWM) begin
            if (hit) begin
                st_d.pin = 1'b1;
            end else if (wrap) begin
                st_d.pin = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_pin = st_q.pin;
    assign cmp_irq = st_q.irq;
endmodule

// File: rtl/pwm_cmp_checker.sv
module pwm_cmp_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic mode_sel,
    input logic cmp_pin,
    input logic cmp_irq
);
    // R1
    reset_outputs_low_chk: assert property (@(posedge clk)
        !rst_n |=> (!cmp_pin && !cmp_irq));

    // R3
    irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq |-> $past(tick));

    // R8
    pin_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sel |=> $stable(cmp_pin));

    // R9
    pin_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_pin) |-> cmp_irq);

    // R9
    pin_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmp_pin) |-> ($past(tick) && $past(mode_sel)));
endmodule

bind pwm_cmp_channel pwm_cmp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode_sel (mode_sel),
    .cmp_pin  (cmp_pin),
    .cmp_irq  (cmp_irq)
);

// File: tb/pwm_cmp_channel_bench.sv
`timescale 1ns/1ps
module pwm_cmp_channel_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic [W-1:0] reload_val = 16'hFFF9;
    logic         mode_sel = 1'b0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         cmp_pin;
    logic         cmp_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_cmp_channel #(.WIDTH(W)) u_pwm_cmp_channel (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reload_val(reload_val),
        .mode_sel(mode_sel), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .cmp_pin(cmp_pin), .cmp_irq(cmp_irq)
    );

    typedef struct packed {
        logic [15:0] reload;
        logic [15:0] cmp;
        logic        mode;
        logic [7:0]  ticks;
        logic [7:0]  exp_irq;
        logic [7:0]  exp_high;
    } vec_t;

    // R2 R5 R6 R8 R9: whole-period counts of interrupts and pin-high steps
    localparam vec_t VECS [7] = '{
        '{16'hFFF9, 16'hFFFC, 1'b1, 8'd21, 8'd3, 8'd12},
        '{16'hFFF9, 16'hFFF9, 1'b1, 8'd21, 8'd3, 8'd15},
        '{16'hFFF9, 16'hFFF8, 1'b1, 8'd21, 8'd0, 8'd0},
        '{16'hFFF9, 16'hFFFC, 1'b0, 8'd21, 8'd3, 8'd0},
        '{16'hFFF9, 16'hFFFF, 1'b1, 8'd21, 8'd3, 8'd3},
        '{16'hFFF0, 16'hFFF0, 1'b1, 8'd32, 8'd2, 8'd17},
        '{16'hFFF9, 16'hFFF9, 1'b0, 8'd21, 8'd3, 8'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick = 1'b0;
        cmp_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_cmp(input logic [W-1:0] v);
        @(negedge clk);
        cmp_wr = 1'b1;
        cmp_wdata = v;
        @(negedge clk);
        cmp_wr = 1'b0;
    endtask

    // one timer step; samples outputs one edge later
    task automatic step(output int irq, output int pin);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        irq = int'(cmp_irq);
        pin = int'(cmp_pin);
    endtask

    task automatic steps(input int n, output int irqs, output int highs, output int last_pin);
        int i_s, p_s;
        irqs = 0;
        highs = 0;
        last_pin = 0;
        for (int k = 0; k < n; k++) begin
            step(i_s, p_s);
            irqs += i_s;
            highs += p_s;
            last_pin = p_s;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int irqs, highs, lp, i1, p1;

        // R1 reset state
        reload_val = 16'hFFF9;
        do_reset();
        @(negedge clk);
        check("R1 pin after reset", int'(cmp_pin), 0);
        check("R1 irq after reset", int'(cmp_irq), 0);

        // vector table
        foreach (VECS[v]) begin
            reload_val = VECS[v].reload;
            mode_sel = VECS[v].mode;
            do_reset();
            write_cmp(VECS[v].cmp);
            steps(int'(VECS[v].ticks), irqs, highs, lp);
            check($sformatf("R2/R5/R6 vec%0d irq count", v), irqs, int'(VECS[v].exp_irq));
            check($sformatf("R8/R9 vec%0d pin-high steps", v), highs, int'(VECS[v].exp_high));
        end

        // R4 one hit per period, R11 single pulse
        reload_val = 16'hFFF9;
        mode_sel = 1'b1;
        do_reset();
        write_cmp(16'hFFFB);
        steps(2, irqs, highs, lp);
        check("R3 hit on FFFB", irqs, 1);
        check("R3 hit seen on last step", int'(cmp_irq), 1);
        @(negedge clk);
        check("R11 irq drops after one cycle", int'(cmp_irq), 0);
        write_cmp(16'hFFFD);
        steps(4, irqs, highs, lp);
        check("R4 rewrite blocked this period", irqs, 0);
        steps(5, irqs, highs, lp);
        check("R4 rewrite hits next period", irqs, 1);

        // R7 value written at current count deferred
        mode_sel = 1'b0;
        do_reset();
        write_cmp(16'hFFF8);
        steps(3, irqs, highs, lp);
        check("R7 no hit before write", irqs, 0);
        write_cmp(16'hFFFC);
        steps(3, irqs, highs, lp);
        check("R7 no hit in current period", irqs, 0);
        steps(4, irqs, highs, lp);
        check("R7 hit in next period", irqs, 1);

        // R5 and R9: rewrite to reload mid-period, set beats clear
        mode_sel = 1'b1;
        do_reset();
        write_cmp(16'hFFFC);
        steps(3, irqs, highs, lp);
        check("R9 pin set by hit", lp, 1);
        write_cmp(16'hFFF9);
        steps(3, irqs, highs, lp);
        check("R4 no hit after reload rewrite", irqs, 0);
        step(i1, p1);
        check("R5 hit at reload count", i1, 1);
        check("R5 pin held high across overflow", p1, 1);
        write_cmp(16'hFFFB);
        steps(2, irqs, highs, lp);
        check("R4 regular value blocked after reload hit", irqs, 0);
        steps(4, irqs, highs, lp);
        check("R5 pin high whole period", highs, 4);
        step(i1, p1);
        check("R9 overflow clears pin", p1, 0);
        check("R9 no irq on overflow", i1, 0);
        steps(2, irqs, highs, lp);
        check("R9 regular hit two periods later", irqs, 1);
        check("R9 pin set again", lp, 1);

        // R8 interrupt-only keeps pin through overflow
        mode_sel = 1'b0;
        steps(5, irqs, highs, lp);
        check("R8 pin kept through overflow", highs, 5);
        steps(2, irqs, highs, lp);
        check("R8 irq still raised", irqs, 1);
        check("R8 pin unchanged by hit", lp, 1);

        // R1 reset clears a high pin
        do_reset();
        @(negedge clk);
        check("R1 reset clears pin", int'(cmp_pin), 0);

        // R10 write and tick at the same edge use the old value
        mode_sel = 1'b1;
        do_reset();
        write_cmp(16'hFFF8);
        @(negedge clk);
        tick = 1'b1;
        cmp_wr = 1'b1;
        cmp_wdata = 16'hFFFA;
        @(negedge clk);
        tick = 1'b0;
        cmp_wr = 1'b0;
        check("R10 old value used on write edge", int'(cmp_irq), 0);
        steps(6, irqs, highs, lp);
        check("R10 no hit rest of period", irqs, 0);
        steps(1, irqs, highs, lp);
        check("R10 new value hits next period", irqs, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule